// File: doc/BRIEF.md
# Double-Buffered Trigger Capture Buffer

This block sits between a digitizer and a readout FIFO. Two equal sample banks take turns. The active bank takes every valid digitized word on each clock and wraps around, so it always holds the most recent samples. A trigger freezes the active bank and moves capture to the other bank in the next cycle. Capture never pauses.

The frozen bank is then streamed out over a valid/ready interface, oldest word first. While it holds data, a busy flag goes back to the trigger source. A trigger that arrives while busy is high is refused and only counted. The frozen bank is released as soon as its last word has been accepted downstream, and it can then be frozen again.

Top module: `trig_pp_buf`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy` and `out_valid` are 0 and `drop_count` is 0.
- R2: A `trig` pulse in a cycle where `busy` is 0 is accepted, and `busy` is 1 in the following cycle.
- R3: An accepted event holds the newest DEPTH valid samples of the active bank, delivered oldest first. A sample presented in the trigger cycle belongs to that event.
- R4: If fewer than DEPTH samples were written since the bank became active, the event carries only those. With zero samples, `busy` is high for exactly one cycle and no word is emitted.
- R5: Samples that arrive while an event is draining are stored in the other bank, and the next accepted event delivers them.
- R6: A `trig` in a cycle where `busy` is 1 has no effect on the event in flight and raises `drop_count` by one.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged in the next cycle.
- R8: `busy` is 0 in the cycle after the last word of an event is accepted (`out_valid` and `out_ready` both 1), so the next trigger is accepted. `out_valid` is never 1 while `busy` is 0.
- R9: `drop_count` is DROP_W bits wide and stops at its all-ones value.
- R10: Cycles with `smp_valid` low store nothing, and their `smp_data` never appears at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and readout clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Digitized word present this cycle |
| smp_data | input | DATA_W | Digitized word |
| trig | input | 1 | Level-1 trigger pulse |
| out_valid | output | 1 | Output word valid |
| out_data | output | DATA_W | Output word toward the readout FIFO |
| out_ready | input | 1 | Downstream accepts a word this cycle |
| busy | output | 1 | A frozen bank holds data not yet delivered |
| drop_count | output | DROP_W | Saturating count of refused triggers |

## Verification
The bench builds the block with DEPTH=4 and DROP_W=3. The small depth means a few samples are enough to wrap the write pointer, so the bench can check that only the newest words survive and that they come out in order. The 3-bit counter reaches saturation after only seven refused triggers.

The bench also covers:
- an empty event,
- stalled readout while the other bank fills,
- a trigger in the first cycle after release.

// File: rtl/trig_pp_pkg.sv
package trig_pp_pkg;
  typedef enum logic {BANK0 = 1'b0, BANK1 = 1'b1} bank_t;

  function automatic bank_t other_bank(input bank_t b);
    return (b == BANK0) ? BANK1 : BANK0;
  endfunction
endpackage

// File: rtl/pp_capture.sv
module pp_capture
  import trig_pp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              accept,
  input  bank_t             rd_bank,
  input  logic [AW-1:0]     rd_addr,
  output bank_t             act_bank,
  output logic [AW-1:0]     frz_start,
  output logic [AW:0]       frz_len,
  output logic [DATA_W-1:0] rd_word
);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  logic [DATA_W-1:0] mem [2*DEPTH];
  bank_t             act_q;
  logic [AW-1:0]     wptr_q, wptr_nx;
  logic [AW:0]       fill_q, fill_nx;

  // plain write port, no reset on contents
  always_ff @(posedge clk) begin
    if (smp_valid) mem[{act_q, wptr_q}] <= smp_data;
  end

  assign rd_word = mem[{rd_bank, rd_addr}];

  always_comb begin
    wptr_nx = smp_valid ? wptr_q + AW'(1) : wptr_q;
    fill_nx = (smp_valid && fill_q != FULL) ? fill_q + (AW+1)'(1) : fill_q;
  end

  // event = the fill_nx words ending just before wptr_nx
  assign frz_len   = fill_nx;
  assign frz_start = wptr_nx - fill_nx[AW-1:0];
  assign act_bank  = act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= BANK0;
      wptr_q <= '0;
      fill_q <= '0;
    end else if (accept) begin
      act_q  <= other_bank(act_q);
      wptr_q <= '0;
      fill_q <= '0;
    end else begin
      wptr_q <= wptr_nx;
      fill_q <= fill_nx;
    end
  end
endmodule

// File: rtl/pp_arbiter.sv
module pp_arbiter #(
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic              release_bank,
  output logic              accept,
  output logic              held,
  output logic [DROP_W-1:0] drop_count
);
  localparam logic [DROP_W-1:0] DROP_MAX = '1;

  logic held_q;
  logic [DROP_W-1:0] drop_q;

  assign accept     = trig && !held_q;
  assign held       = held_q;
  assign drop_count = drop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 1'b0;
      drop_q <= '0;
    end else begin
      if (accept)            held_q <= 1'b1;
      else if (release_bank) held_q <= 1'b0;
      if (trig && held_q && drop_q != DROP_MAX) drop_q <= drop_q + DROP_W'(1);
    end
  end
endmodule

// File: rtl/pp_readout.sv
module pp_readout
  import trig_pp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              held,
  input  bank_t             act_bank,
  input  logic [AW-1:0]     frz_start,
  input  logic [AW:0]       frz_len,
  input  logic [DATA_W-1:0] rd_word,
  input  logic              out_ready,
  output bank_t             rd_bank,
  output logic [AW-1:0]     rd_addr,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              release_bank
);
  bank_t             bank_q;
  logic [AW-1:0]     ptr_q;
  logic [AW:0]       left_q;
  logic              ov_q;
  logic [DATA_W-1:0] od_q;
  logic              slot_free, load;

  assign slot_free    = !ov_q || out_ready;
  assign load         = held && left_q != '0 && slot_free;
  assign release_bank = held && left_q == '0 && slot_free;
  assign rd_bank      = bank_q;
  assign rd_addr      = ptr_q;
  assign out_valid    = ov_q;
  assign out_data     = od_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= BANK0;
      ptr_q  <= '0;
      left_q <= '0;
      ov_q   <= 1'b0;
      od_q   <= '0;
    end else begin
      if (accept) begin
        bank_q <= act_bank;
        ptr_q  <= frz_start;
        left_q <= frz_len;
      end else if (load) begin
        ptr_q  <= ptr_q + AW'(1);
        left_q <= left_q - (AW+1)'(1);
      end
      if (load) begin
        od_q <= rd_word;
        ov_q <= 1'b1;
      end else if (out_ready) begin
        ov_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/trig_pp_buf.sv
module trig_pp_buf
  import trig_pp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int DROP_W = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              trig,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              busy,
  output logic [DROP_W-1:0] drop_count
);
  logic              accept, held, release_bank;
  bank_t             act_bank, rd_bank;
  logic [AW-1:0]     frz_start, rd_addr;
  logic [AW:0]       frz_len;
  logic [DATA_W-1:0] rd_word;

  pp_capture #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_cap (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .accept(accept), .rd_bank(rd_bank), .rd_addr(rd_addr),
    .act_bank(act_bank), .frz_start(frz_start), .frz_len(frz_len),
    .rd_word(rd_word)
  );

  pp_arbiter #(.DROP_W(DROP_W)) u_arb (
    .clk(clk), .rst(rst), .trig(trig), .release_bank(release_bank),
    .accept(accept), .held(held), .drop_count(drop_count)
  );

  pp_readout #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst(rst), .accept(accept), .held(held),
    .act_bank(act_bank), .frz_start(frz_start), .frz_len(frz_len),
    .rd_word(rd_word), .out_ready(out_ready), .rd_bank(rd_bank),
    .rd_addr(rd_addr), .out_valid(out_valid), .out_data(out_data),
    .release_bank(release_bank)
  );

  assign busy = held;
endmodule

// File: rtl/pp_checker.sv
module pp_checker #(
  parameter int DATA_W = 32,
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              trig,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_ready,
  input logic              busy,
  input logic [DROP_W-1:0] drop_count
);
  localparam logic [DROP_W-1:0] DMAX = '1;

  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (!busy && !out_valid && drop_count == '0));

  a_r2_trig_sets_busy: assert property (@(posedge clk) disable iff (rst)
    (trig && !busy) |=> busy);

  a_r6_drop_counts: assert property (@(posedge clk) disable iff (rst)
    (trig && busy && drop_count != DMAX) |=> drop_count == $past(drop_count) + DROP_W'(1));

  a_r6_no_spurious_drop: assert property (@(posedge clk) disable iff (rst)
    !(trig && busy) |=> $stable(drop_count));

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r8_valid_needs_busy: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> busy);

  a_r9_drop_saturates: assert property (@(posedge clk) disable iff (rst)
    (drop_count == DMAX) |=> (drop_count == DMAX));
endmodule

bind trig_pp_buf pp_checker #(.DATA_W(DATA_W), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst(rst), .trig(trig), .out_valid(out_valid),
  .out_data(out_data), .out_ready(out_ready), .busy(busy),
  .drop_count(drop_count)
);

// File: tb/sim_trig_pp_buf.sv
`timescale 1ns/1ps
module sim_trig_pp_buf;
  localparam int DW = 32, DP = 4, DRW = 3;

  logic clk = 1'b0, rst = 1'b1, smp_valid = 1'b0, trig = 1'b0, out_ready = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic out_valid, busy;
  logic [DW-1:0] out_data;
  logic [DRW-1:0] drop_count;
  int total = 0, bad = 0;
  logic [DW-1:0] expq [0:15];

  always #2.5 clk = ~clk;

  trig_pp_buf #(.DATA_W(DW), .DEPTH(DP), .DROP_W(DRW)) u0 (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .trig(trig), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .busy(busy), .drop_count(drop_count)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [31:0] d, input bit t);
    @(negedge clk);
    smp_valid = v; smp_data = d; trig = t;
    @(posedge clk); #1;
  endtask

  task automatic collect(input int n, input bit stall, input string tag);
    logic [DW-1:0] got [0:15];
    int k = 0;
    for (int c = 0; c < 200 && k < n; c++) begin
      @(negedge clk);
      smp_valid = 1'b0; trig = 1'b0;
      out_ready = stall ? (c % 3 != 1) : 1'b1;
      #1;
      if (out_valid && out_ready) begin got[k] = out_data; k++; end
    end
    @(posedge clk); #1;
    chk(busy == 1'b0, {tag, " R8 busy low after last word"}, 32'(busy), 0);
    @(negedge clk); out_ready = 1'b0;
    chk(k == n, {tag, " word count"}, 32'(k), 32'(n));
    for (int i = 0; i < n && i < k; i++)
      chk(got[i] == expq[i], {tag, " word value"}, got[i], expq[i]);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk(busy == 0, "R1 busy after reset", 32'(busy), 0);
    chk(out_valid == 0, "R1 out_valid after reset", 32'(out_valid), 0);
    chk(drop_count == 0, "R1 drop_count after reset", 32'(drop_count), 0);
  endtask

  task automatic t_short();
    step(1, 32'hA000_0000, 0);
    step(1, 32'hA000_0001, 0);
    step(0, 32'hBAD0_0000, 1);
    chk(busy == 1, "R2 busy after trigger", 32'(busy), 1);
    expq[0] = 32'hA000_0000; expq[1] = 32'hA000_0001;
    collect(2, 0, "R4 short event");
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 7; i++) begin
      step(1, 32'hC000_0000 + 32'(i), 0);
      step(0, 32'hBAD1_0000 + 32'(i), 0);  // R10 junk with valid low
    end
    step(1, 32'hC000_0007, 1);
    chk(busy == 1, "R2 busy after wrap trigger", 32'(busy), 1);
    for (int i = 0; i < 4; i++) expq[i] = 32'hC000_0004 + 32'(i);
    collect(4, 1, "R3 R10 wrapped event");
  endtask

  task automatic t_overlap();
    logic [DW-1:0] held_word;
    for (int i = 0; i < 3; i++) step(1, 32'hD000_0000 + 32'(i), 0);
    step(1, 32'hD000_0003, 1);
    step(1, 32'hE000_0000, 0);
    chk(out_valid == 1, "R7 first word presented", 32'(out_valid), 1);
    held_word = out_data;
    chk(held_word == 32'hD000_0000, "R3 first word value", held_word, 32'hD000_0000);
    step(1, 32'hE000_0001, 1);
    chk(out_valid == 1 && out_data == held_word, "R7 stall hold 1", out_data, held_word);
    step(1, 32'hE000_0002, 1);
    chk(out_valid == 1 && out_data == held_word, "R7 stall hold 2", out_data, held_word);
    chk(drop_count == 2, "R6 refused triggers counted", 32'(drop_count), 2);
    for (int i = 0; i < 4; i++) expq[i] = 32'hD000_0000 + 32'(i);
    collect(4, 0, "R6 event unaffected");
    step(1, 32'hE000_0003, 1);
    chk(busy == 1, "R8 trigger right after release accepted", 32'(busy), 1);
    for (int i = 0; i < 4; i++) expq[i] = 32'hE000_0000 + 32'(i);
    collect(4, 0, "R5 captured during drain");
  endtask

  task automatic t_empty();
    step(0, 32'hBAD2_0000, 1);
    chk(busy == 1 && out_valid == 0, "R4 empty event busy cycle", {busy, out_valid}, 2);
    step(0, 32'hBAD2_0001, 0);
    chk(busy == 0 && out_valid == 0, "R4 empty event released", {busy, out_valid}, 0);
  endtask

  task automatic t_sat();
    step(1, 32'hF000_0000, 1);
    for (int i = 0; i < 8; i++) step(0, 32'hBAD3_0000, 1);
    chk(drop_count == 7, "R9 drop_count saturated", 32'(drop_count), 7);
    step(0, 32'hBAD3_0001, 0);
    chk(drop_count == 7, "R9 drop_count holds", 32'(drop_count), 7);
    expq[0] = 32'hF000_0000;
    collect(1, 0, "R9 drain after saturation");
  endtask

  initial begin
    t_reset();
    t_short();
    t_wrap();
    t_overlap();
    t_empty();
    t_sat();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(100000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule